// File: doc/BRIEF.md
# Write Busy Status Read Generator

This block forms the byte a self-timed nonvolatile memory presents on its read port while an internal programming period may be running. The write engine supplies a busy flag and the last byte it loaded. The array supplies the stored word. The host side supplies chip enable and output enable, both active high here. While busy is high, a read returns two completion indicators merged into one word. The top bit is the inverse of the top bit of the last loaded byte. The bit below it flips on every new read access. All other bits are zero.

When busy is low, a read returns the stored word unchanged. When either enable is inactive, the output-enable flag drops and the data lines are driven to zero. Every output is registered, so it reflects the inputs sampled one clock earlier. A write refused by software protection still raises busy for the full write period. Reads during that time are therefore status reads, although nothing is stored.

Top module: `bsr_status_read`

## Requirements
- R1: While reset is high, and in the first cycle after it, `data_oe_o` is 0 and `data_o` is all zeros, whatever the other inputs are.
- R2: When `chip_en_i` or `out_en_i` is 0 in a cycle, the next cycle shows `data_oe_o` = 0 and `data_o` = 0.
- R3: When both enables are 1 and `busy_i` is 0 in a cycle, the next cycle shows `data_oe_o` = 1 and `data_o` equal to that cycle's `array_i`.
- R4: When both enables are 1 and `busy_i` is 1, the next cycle shows `data_oe_o` = 1 and bit 7 of `data_o` equal to the inverse of bit 7 of `last_byte_i`. The stored data plays no part in this.
- R5: During such a busy read, bits 5 down to 0 of `data_o` are zero.
- R6: A new access is a cycle in which both enables are 1 after a cycle in which they were not. A new access while busy gives bit 6 of `data_o` the inverse of the bit 6 value from the previous busy read.
- R7: While both enables stay 1 over several busy cycles, bit 6 keeps the same value.
- R8: A new access begins on whichever enable becomes active last. Pulsing only `out_en_i` with `chip_en_i` held advances bit 6. Pulsing only `chip_en_i` with `out_en_i` held also advances it.
- R9: Reads while idle do not advance the toggle. The first new busy access after an idle stretch shows bit 6 inverted from the last busy read before that stretch.
- R10: If `busy_i` rises during a held access, the next cycle already shows the status word. Its bit 6 equals the value from the last busy read, because no new access occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_en_i | input | 1 | Chip enable, active high |
| out_en_i | input | 1 | Output enable, active high |
| busy_i | input | 1 | Internal programming period in progress |
| last_byte_i | input | DATA_W | Last data word loaded by the write engine |
| array_i | input | DATA_W | Stored word at the current address |
| data_o | output | DATA_W | Read data or status word |
| data_oe_o | output | 1 | Output drive enable; 0 means the output is high impedance |

## Verification
The hardest cases to reach are those where a new access and a level change of busy fall close together. One case is busy rising inside a held read. Another is the toggle resuming after an idle stretch that contained reads. Random stimulus seldom lines these up. Directed sequences therefore hold one enable and pulse the other, raise busy mid-read, and interleave idle reads between busy reads. Long random runs of enables and busy then follow. The bench model does not fix the toggle's absolute value: it adopts the first observed value and checks every later value against it.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef struct packed {
    logic active;
    logic start;
  } bsr_access_t;
endpackage

// File: rtl/bsr_access_detect.sv
module bsr_access_detect
  import bsr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        chip_en_i,
  input  logic        out_en_i,
  output bsr_access_t acc_o
);
  logic act;
  logic act_q;

  assign act = chip_en_i & out_en_i;

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= act;
  end

  assign acc_o.active = act;
  assign acc_o.start  = act & ~act_q;
endmodule

// File: rtl/bsr_toggle.sv
module bsr_toggle (
  input  logic clk,
  input  logic rst,
  input  logic advance_i,
  output logic tog_next_o
);
  logic tog_q;

  assign tog_next_o = tog_q ^ advance_i;

  always_ff @(posedge clk) begin
    if (rst) tog_q <= 1'b0;
    else     tog_q <= tog_next_o;
  end
endmodule

// File: rtl/bsr_out_reg.sv
module bsr_out_reg
  import bsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bsr_access_t       acc_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] last_byte_i,
  input  logic [DATA_W-1:0] array_i,
  input  logic              tog_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  logic [DATA_W-1:0] status_w;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_stat
      if (gi == POLL_BIT) begin : g_poll
        assign status_w[gi] = ~last_byte_i[gi];
      end else if (gi == TOG_BIT) begin : g_tog
        assign status_w[gi] = tog_i;
      end else begin : g_zero
        assign status_w[gi] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o    <= '0;
      data_oe_o <= 1'b0;
    end else begin
      data_oe_o <= acc_i.active;
      if (!acc_i.active) data_o <= '0;
      else if (busy_i)   data_o <= status_w;
      else               data_o <= array_i;
    end
  end
endmodule

// File: rtl/bsr_status_read.sv
module bsr_status_read
  import bsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_en_i,
  input  logic              out_en_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] last_byte_i,
  input  logic [DATA_W-1:0] array_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  bsr_access_t acc;
  logic        adv;
  logic        tog_next;

  bsr_access_detect u_acc (
    .clk       (clk),
    .rst       (rst),
    .chip_en_i (chip_en_i),
    .out_en_i  (out_en_i),
    .acc_o     (acc)
  );

  assign adv = acc.start & busy_i;

  bsr_toggle u_tog (
    .clk        (clk),
    .rst        (rst),
    .advance_i  (adv),
    .tog_next_o (tog_next)
  );

  bsr_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .acc_i       (acc),
    .busy_i      (busy_i),
    .last_byte_i (last_byte_i),
    .array_i     (array_i),
    .tog_i       (tog_next),
    .data_o      (data_o),
    .data_oe_o   (data_oe_o)
  );
endmodule

// File: rtl/bsr_status_read_chk.sv
module bsr_status_read_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              chip_en_i,
  input logic              out_en_i,
  input logic              busy_i,
  input logic [DATA_W-1:0] last_byte_i,
  input logic [DATA_W-1:0] array_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic              adv,
  input logic              tog_next
);
  localparam int TB = DATA_W - 2;
  localparam int PB = DATA_W - 1;

  logic act;
  logic r_ok;
  logic r_tog;
  logic r_act;

  assign act = chip_en_i & out_en_i;

  always_ff @(posedge clk) begin
    r_ok  <= ~rst;
    r_tog <= tog_next;
    r_act <= rst ? 1'b0 : act;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!data_oe_o && data_o == '0)); // R1
  AST_HIZ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !act |=> (!data_oe_o && data_o == '0)); // R2
  AST_IDLE_TRUE: assert property (@(posedge clk) disable iff (rst)
    (act && !busy_i) |=> (data_oe_o && data_o == $past(array_i))); // R3
  AST_POLL_INV: assert property (@(posedge clk) disable iff (rst)
    (act && busy_i) |=> (data_oe_o && data_o[PB] == ~$past(last_byte_i[PB]))); // R4
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (act && busy_i) |=> (data_o[TB-1:0] == '0)); // R5
  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (rst)
    (r_ok && adv) |=> (data_o[TB] == ~$past(r_tog))); // R6
  AST_TOG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (r_ok && act && r_act && busy_i) |=> (data_o[TB] == $past(r_tog))); // R7
endmodule

bind bsr_status_read bsr_status_read_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .chip_en_i   (chip_en_i),
  .out_en_i    (out_en_i),
  .busy_i      (busy_i),
  .last_byte_i (last_byte_i),
  .array_i     (array_i),
  .data_o      (data_o),
  .data_oe_o   (data_oe_o),
  .adv         (adv),
  .tog_next    (tog_next)
);

// File: tb/bsr_status_read_tb.sv
module bsr_status_read_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ce = 1'b0, oe = 1'b0, busy = 1'b0;
  logic [W-1:0] last = '0, arr = '0;
  logic [W-1:0] data_o;
  logic         data_oe_o;

  int checks = 0;
  int errors = 0;
  bit m_prev = 1'b0;
  bit m_tog = 1'b0;
  bit m_known = 1'b0;

  always #10 clk = ~clk;

  bsr_status_read #(.DATA_W(W)) u_dut (
    .clk(clk), .rst(rst), .chip_en_i(ce), .out_en_i(oe), .busy_i(busy),
    .last_byte_i(last), .array_i(arr), .data_o(data_o), .data_oe_o(data_oe_o)
  );

  task automatic chk(input string tag, input logic [W:0] act_v, input logic [W:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act_v, exp_v);
    end
  endtask

  function automatic logic [W:0] exp_word(input bit a, input bit b,
      input logic [W-1:0] lb, input logic [W-1:0] ar, input bit t);
    logic [W-1:0] d;
    if (!a) return {1'b0, {W{1'b0}}};
    if (!b) return {1'b1, ar};
    d = '0;
    d[W-1] = ~lb[W-1];
    d[W-2] = t;
    return {1'b1, d};
  endfunction

  task automatic cyc(input bit c, input bit o, input bit b,
      input logic [W-1:0] lb, input logic [W-1:0] ar, input string ttag);
    bit a, nw;
    @(negedge clk);
    ce = c; oe = o; busy = b; last = lb; arr = ar;
    a = c & o;
    nw = a & ~m_prev;
    m_prev = a;
    @(negedge clk);
    if (!a) chk("R2", {data_oe_o, data_o}, exp_word(0, b, lb, ar, 0));
    else if (!b) chk("R3", {data_oe_o, data_o}, exp_word(1, 0, lb, ar, 0));
    else begin
      if (nw) m_tog = ~m_tog;
      if (!m_known) begin m_tog = data_o[W-2]; m_known = 1'b1; end
      chk("R4 R5", {data_oe_o, data_o[W-1], data_o[W-3:0]},
          {1'b1, ~lb[W-1], {(W-2){1'b0}}});
      chk(ttag, {{W{1'b0}}, data_o[W-2]}, {{W{1'b0}}, m_tog});
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: reset with active inputs
    ce = 1; oe = 1; busy = 1; arr = 8'hA5; last = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1", {data_oe_o, data_o}, '0);
    @(negedge clk);
    ce = 0; oe = 0; busy = 0;
    rst = 0;
    @(negedge clk);
    chk("R1", {data_oe_o, data_o}, '0);
    m_prev = 0;

    // R3 idle reads, R2 disabled
    cyc(1, 1, 0, 8'h00, 8'h3C, "R3");
    cyc(1, 1, 0, 8'h00, 8'hC3, "R3");
    cyc(0, 1, 0, 8'h00, 8'hFF, "R2");
    cyc(1, 0, 0, 8'h00, 8'hFF, "R2");
    // R6 successive busy accesses
    cyc(1, 1, 1, 8'h80, 8'hFF, "R6");
    cyc(0, 0, 1, 8'h80, 8'hFF, "R6");
    cyc(1, 1, 1, 8'h00, 8'hFF, "R6");
    cyc(1, 1, 1, 8'h00, 8'hFF, "R7");
    cyc(1, 1, 1, 8'h7F, 8'hFF, "R7");
    // R8: oe pulses with ce held, then ce pulses with oe held
    for (int i = 0; i < 3; i++) begin
      cyc(1, 0, 1, 8'h80, 8'h11, "R8");
      cyc(1, 1, 1, 8'h80, 8'h11, "R8");
    end
    for (int i = 0; i < 3; i++) begin
      cyc(0, 1, 1, 8'h01, 8'h22, "R8");
      cyc(1, 1, 1, 8'h01, 8'h22, "R8");
    end
    // R9: idle reads between busy reads
    cyc(0, 0, 0, 8'h00, 8'h00, "R9");
    cyc(1, 1, 0, 8'h00, 8'h5A, "R9");
    cyc(0, 0, 0, 8'h00, 8'h00, "R9");
    cyc(1, 1, 0, 8'h00, 8'hA5, "R9");
    cyc(0, 0, 1, 8'h00, 8'h00, "R9");
    cyc(1, 1, 1, 8'h00, 8'h00, "R9");
    // R10: busy rises inside a held read
    cyc(0, 0, 0, 8'h00, 8'h00, "R10");
    cyc(1, 1, 0, 8'h00, 8'h66, "R10");
    cyc(1, 1, 1, 8'h80, 8'h66, "R10");
    cyc(1, 1, 1, 8'h80, 8'h66, "R10");

    // random runs
    begin
      int run = 0;
      bit b = 0;
      for (int i = 0; i < 4000; i++) begin
        if (run == 0) begin b = ~b; run = 1 + $urandom % 40; end
        run--;
        cyc(($urandom % 4) != 0, ($urandom % 3) != 0, b,
            W'($urandom), W'($urandom), "R6");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule